// File: doc/BRIEF.md
# Postfix Stack Expression Evaluator

This block evaluates integer expressions written in postfix order. A producer hands it one token per cycle: an operand carries a 16-bit two's complement value, and an operator names an arithmetic operation. Operands go onto an internal hardware stack. Operators take the two newest entries off the stack, combine them, and put the single result back. An end token reports the value on top of the stack as the expression result and empties the stack, ready for the next expression.

The two newest entries sit in registers and the deeper entries form a shift chain, so every token finishes in a single clock cycle and no read spans more than one cycle. Errors (an operator with too few entries, a push onto a full stack) raise a one-cycle flag and leave the stack as it was, so the producer can tell a malformed expression apart from a good result.

Top module: `pfx_eval`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `stk_depth` is 0, and `res_valid`, `err_under` and `err_over` are low; `tok_ready` is low during reset and high in every cycle after reset.
- R2: A token with `tok_op` = 0 (operand) and fewer than 8 entries on the stack pushes `tok_data` as the new top and raises `stk_depth` by one in the following cycle.
- R3: Operators are `tok_op` = 1 (add), 2 (subtract) and 3 (multiply); the older of the two top entries is the left operand and the newer one the right operand, and the result keeps the low 16 bits (so 4, 3, subtract, 5, add leaves 6).
- R4: An operator with at least two entries on the stack lowers `stk_depth` by exactly one; for 4, 3, subtract, 5, add the depth after each token is 1, 2, 1, 2, 1.
- R5: An operator arriving with fewer than two entries raises `err_under` for one cycle and leaves depth and contents unchanged.
- R6: An operand arriving with 8 entries on the stack raises `err_over` for one cycle, drops the value and leaves depth and contents unchanged.
- R7: An end token (`tok_op` = 4) with at least one entry raises `res_valid` for exactly one cycle with the top entry on `res_data` and leaves `stk_depth` at 0; an end token on an empty stack raises `err_under` instead and produces no result.
- R8: A cycle with `tok_valid` low, or with `tok_op` of 5, 6 or 7, changes nothing: no flag rises and depth and contents stay as they were.
- R9: `res_valid`, `err_under` and `err_over` are each high only in the cycle directly after an accepted token, and never two of them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | A token is offered this cycle |
| tok_ready | output | 1 | Block accepts a token this cycle |
| tok_op | input | 3 | Token kind: 0 operand, 1 add, 2 subtract, 3 multiply, 4 end, others ignored |
| tok_data | input | 16 | Operand value, two's complement |
| res_valid | output | 1 | One-cycle strobe: `res_data` holds an expression result |
| res_data | output | 16 | Result of the last end token |
| err_under | output | 1 | One-cycle strobe: too few entries for the token |
| err_over | output | 1 | One-cycle strobe: operand dropped on a full stack |
| stk_depth | output | 4 | Number of entries on the stack |

## Verification
The bench aims at operand order, where a design that swapped the entries would return 3 − 4 instead of 4 − 3 and wrong products never show it; at the full and empty boundaries, where an off-by-one would accept a ninth operand or pop a phantom entry; and at the entries below the two top registers, which a broken shift chain would lose only once an expression grows deeper than two. It also drives end tokens on an empty stack and ignored opcodes, where a careless decode would emit a stale result or disturb the stack. Random traffic mixes all of these against a reference stack kept in the bench.

// File: rtl/pfx_pkg.sv
// Package: shared widths, token codes and stack commands for the postfix evaluator.
// Assumes: token codes are fixed by the producer interface (0..4 meaningful).
package pfx_pkg;

    localparam int OP_W = 3;

    // Token kinds as carried on tok_op
    typedef enum logic [OP_W-1:0] {
        TK_PUSH = 3'd0,
        TK_ADD  = 3'd1,
        TK_SUB  = 3'd2,
        TK_MUL  = 3'd3,
        TK_END  = 3'd4
    } tok_kind_t;

    // Arithmetic selector for the operator unit
    typedef enum logic [1:0] {
        AL_ADD = 2'd0,
        AL_SUB = 2'd1,
        AL_MUL = 2'd2
    } alu_sel_t;

    // Stack update commands
    typedef enum logic [1:0] {
        SK_HOLD  = 2'd0,
        SK_PUSH  = 2'd1,
        SK_FOLD  = 2'd2,
        SK_CLEAR = 2'd3
    } stk_cmd_t;

endpackage

// File: rtl/pfx_alu.sv
// Module: pfx_alu
// Combines the two newest stack entries. lhs is the older entry, rhs the
// newer one. Results wrap to DATA_W bits; purely combinational.
module pfx_alu
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_sel_t            sel,
    input  logic [DATA_W-1:0]   lhs,
    input  logic [DATA_W-1:0]   rhs,
    output logic [DATA_W-1:0]   res
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] prod;

    // Full product; only the low half is kept
    always_comb begin
        prod = PROD_W'(lhs) * PROD_W'(rhs);
    end

    // Operation select
    always_comb begin
        unique case (sel)
            AL_ADD:  res = lhs + rhs;
            AL_SUB:  res = lhs - rhs;
            AL_MUL:  res = prod[DATA_W-1:0];
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pfx_stack.sv
// Module: pfx_stack
// Bounded stack with the newest two entries in dedicated registers and the
// rest in a shift chain, so push, fold (pop two, push one) and clear each
// complete in one cycle. Assumes the controller never pushes when full and
// never folds with fewer than two entries.
module pfx_stack
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  stk_cmd_t                cmd,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       top,
    output logic [DATA_W-1:0]       second,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int LOW_N = DEPTH - 2;

    logic [DATA_W-1:0] top_q, sec_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] low_q [LOW_N];

    // Top register: new operand on push, fold result on fold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (cmd == SK_PUSH || cmd == SK_FOLD) begin
            top_q <= wdata;
        end
    end

    // Second register: old top on push, first chain slot on fold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (cmd == SK_PUSH) begin
            sec_q <= top_q;
        end else if (cmd == SK_FOLD) begin
            sec_q <= low_q[0];
        end
    end

    // Deeper entries: shift down on push, up on fold
    generate
        for (genvar i = 0; i < LOW_N; i++) begin : g_low
            logic [DATA_W-1:0] from_above, from_below;
            if (i == 0) begin : g_first
                assign from_above = sec_q;
            end else begin : g_mid
                assign from_above = low_q[i-1];
            end
            if (i == LOW_N - 1) begin : g_last
                assign from_below = '0;
            end else begin : g_inner
                assign from_below = low_q[i+1];
            end

            // Slot i of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_q[i] <= '0;
                end else if (cmd == SK_PUSH) begin
                    low_q[i] <= from_above;
                end else if (cmd == SK_FOLD) begin
                    low_q[i] <= from_below;
                end
            end
        end
    endgenerate

    // Entry count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                SK_PUSH:  cnt_q <= cnt_q + CNT_W'(1);
                SK_FOLD:  cnt_q <= cnt_q - CNT_W'(1);
                SK_CLEAR: cnt_q <= '0;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign top    = top_q;
    assign second = sec_q;
    assign count  = cnt_q;

endmodule

// File: rtl/pfx_eval.sv
// Module: pfx_eval (top)
// Postfix expression evaluator: one token per cycle, operands pushed,
// operators fold the two newest entries, end token emits the top and
// empties the stack. Error and result strobes are registered and appear
// the cycle after the token. Assumes tok_op codes from pfx_pkg.
module pfx_eval
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tok_valid,
    output logic                        tok_ready,
    input  logic [2:0]                  tok_op,
    input  logic [DATA_W-1:0]           tok_data,
    output logic                        res_valid,
    output logic [DATA_W-1:0]           res_data,
    output logic                        err_under,
    output logic                        err_over,
    output logic [$clog2(DEPTH+1)-1:0]  stk_depth
);

    localparam int CNT_W = $clog2(DEPTH+1);

    logic                rdy_q;
    logic                take;
    logic                is_push, is_arith, is_end;
    logic                full, has_two, has_one;
    alu_sel_t            alu_sel;
    logic [DATA_W-1:0]   alu_res;
    logic [DATA_W-1:0]   st_top, st_sec;
    logic [CNT_W-1:0]    st_cnt;
    stk_cmd_t            cmd;
    logic [DATA_W-1:0]   wdata;
    logic                under_d, over_d, res_d;
    logic                res_v_q, under_q, over_q;
    logic [DATA_W-1:0]   res_q;

    // Ready comes up the cycle after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    assign tok_ready = rdy_q;
    assign take      = tok_valid && rdy_q;

    // Token decode
    always_comb begin
        is_push  = take && (tok_op == TK_PUSH);
        is_arith = take && (tok_op == TK_ADD || tok_op == TK_SUB || tok_op == TK_MUL);
        is_end   = take && (tok_op == TK_END);
        unique case (tok_op)
            TK_SUB:  alu_sel = AL_SUB;
            TK_MUL:  alu_sel = AL_MUL;
            default: alu_sel = AL_ADD;
        endcase
    end

    // Occupancy tests
    assign full    = (st_cnt == CNT_W'(DEPTH));
    assign has_two = (st_cnt >= CNT_W'(2));
    assign has_one = (st_cnt != '0);

    pfx_alu #(.DATA_W(DATA_W)) u_alu (
        .sel (alu_sel),
        .lhs (st_sec),
        .rhs (st_top),
        .res (alu_res)
    );

    // Stack command, write data and error detection
    always_comb begin
        cmd     = SK_HOLD;
        wdata   = tok_data;
        under_d = 1'b0;
        over_d  = 1'b0;
        res_d   = 1'b0;
        if (is_push) begin
            if (full) over_d = 1'b1;
            else      cmd    = SK_PUSH;
        end else if (is_arith) begin
            if (has_two) begin
                cmd   = SK_FOLD;
                wdata = alu_res;
            end else begin
                under_d = 1'b1;
            end
        end else if (is_end) begin
            if (has_one) begin
                cmd   = SK_CLEAR;
                res_d = 1'b1;
            end else begin
                under_d = 1'b1;
            end
        end
    end

    pfx_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .wdata  (wdata),
        .top    (st_top),
        .second (st_sec),
        .count  (st_cnt)
    );

    // Registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_v_q <= 1'b0;
            under_q <= 1'b0;
            over_q  <= 1'b0;
        end else begin
            res_v_q <= res_d;
            under_q <= under_d;
            over_q  <= over_d;
        end
    end

    // Result value captured on a good end token
    always_ff @(posedge clk) begin
        if (!rst_n)     res_q <= '0;
        else if (res_d) res_q <= st_top;
    end

    assign res_valid = res_v_q;
    assign res_data  = res_q;
    assign err_under = under_q;
    assign err_over  = over_q;
    assign stk_depth = st_cnt;

endmodule

// File: rtl/pfx_eval_chk.sv
// Module: pfx_eval_chk
// Port-level timing properties of the evaluator, bound to every pfx_eval.
module pfx_eval_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tok_valid,
    input logic                        tok_ready,
    input logic [2:0]                  tok_op,
    input logic [DATA_W-1:0]           tok_data,
    input logic                        res_valid,
    input logic [DATA_W-1:0]           res_data,
    input logic                        err_under,
    input logic                        err_over,
    input logic [$clog2(DEPTH+1)-1:0]  stk_depth
);

    localparam int CNT_W = $clog2(DEPTH+1);

    logic acc, is_opr;
    assign acc    = tok_valid && tok_ready;
    assign is_opr = (tok_op >= 3'd1) && (tok_op <= 3'd3);

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && tok_op == 3'd0 && stk_depth < CNT_W'(DEPTH)
        |=> stk_depth == $past(stk_depth) + CNT_W'(1) && !err_over);

    // R4
    fold_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_opr && stk_depth >= CNT_W'(2)
        |=> stk_depth == $past(stk_depth) - CNT_W'(1) && !err_under);

    // R5
    under_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_opr && stk_depth < CNT_W'(2)
        |=> err_under && $stable(stk_depth));

    // R6
    over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && tok_op == 3'd0 && stk_depth == CNT_W'(DEPTH)
        |=> err_over && stk_depth == CNT_W'(DEPTH));

    // R7
    end_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && tok_op == 3'd4 && stk_depth != '0
        |=> res_valid && stk_depth == '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> $stable(stk_depth) && !res_valid && !err_under && !err_over);

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_valid, err_under, err_over}) <= 1);

    // R1
    ready_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |=> tok_ready);

    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= CNT_W'(DEPTH));

endmodule

bind pfx_eval pfx_eval_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pfx_eval_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_op    (tok_op),
    .tok_data  (tok_data),
    .res_valid (res_valid),
    .res_data  (res_data),
    .err_under (err_under),
    .err_over  (err_over),
    .stk_depth (stk_depth)
);

// File: tb/pfx_eval_bench.sv
// Bench: directed corner cases plus seeded random tokens, checked against a
// reference stack model kept in the bench.
module pfx_eval_bench;

    localparam int DW = 16;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_valid = 1'b0;
    logic          tok_ready;
    logic [2:0]    tok_op = '0;
    logic [DW-1:0] tok_data = '0;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic          err_under, err_over;
    logic [3:0]    stk_depth;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] mstk [DP];
    int            mcnt = 0;

    always #10 clk = ~clk;

    pfx_eval u_pfx_eval (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_op(tok_op), .tok_data(tok_data), .res_valid(res_valid),
        .res_data(res_data), .err_under(err_under), .err_over(err_over),
        .stk_depth(stk_depth)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] calc(input logic [2:0] op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
        logic [2*DW-1:0] p;
        p = 32'(a) * 32'(b);
        case (op)
            3'd1:    return a + b;
            3'd2:    return a - b;
            default: return p[DW-1:0];
        endcase
    endfunction

    // Drive one token, update the model, check all outputs one cycle later
    task automatic send(input bit v, input logic [2:0] op, input logic [DW-1:0] d,
                        input string tag);
        bit e_res, e_und, e_ovr;
        logic [DW-1:0] e_val;
        e_res = 0; e_und = 0; e_ovr = 0; e_val = res_data;
        if (v) begin
            if (op == 3'd0) begin
                if (mcnt == DP) e_ovr = 1;
                else begin mstk[mcnt] = d; mcnt++; end
            end else if (op >= 3'd1 && op <= 3'd3) begin
                if (mcnt < 2) e_und = 1;
                else begin
                    mstk[mcnt-2] = calc(op, mstk[mcnt-2], mstk[mcnt-1]);
                    mcnt--;
                end
            end else if (op == 3'd4) begin
                if (mcnt == 0) e_und = 1;
                else begin e_res = 1; e_val = mstk[mcnt-1]; mcnt = 0; end
            end
        end
        tok_valid = v; tok_op = op; tok_data = d;
        @(posedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
        chk(res_valid == e_res, {tag, " res_valid"}, res_valid, e_res);
        if (e_res) chk(res_data == e_val, {tag, " res_data"}, res_data, e_val);
        chk(err_under == e_und, {tag, " err_under"}, err_under, e_und);
        chk(err_over == e_ovr, {tag, " err_over"}, err_over, e_ovr);
        chk(stk_depth == 4'(mcnt), {tag, " depth"}, stk_depth, mcnt);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(stk_depth == 0 && !res_valid && !err_under && !err_over && !tok_ready,
            "R1 in reset", stk_depth, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tok_ready == 1'b1, "R1 ready", tok_ready, 1);
        chk(stk_depth == 0, "R1 depth", stk_depth, 0);

        // R3 R4 worked example with depth trace
        send(1, 3'd0, 16'd4, "R2 push4");
        send(1, 3'd0, 16'd3, "R2 push3");
        send(1, 3'd2, 16'd0, "R4 sub");
        send(1, 3'd0, 16'd5, "R2 push5");
        send(1, 3'd1, 16'd0, "R4 add");
        send(1, 3'd4, 16'd0, "R3 end 6");
        chk(res_data == 16'd6, "R3 example", res_data, 6);

        // R3 negative subtract and multiply wrap
        send(1, 3'd0, 16'd2, "R3 a");
        send(1, 3'd0, 16'd5, "R3 b");
        send(1, 3'd2, 16'd0, "R3 sub");
        send(1, 3'd4, 16'd0, "R3 end neg");
        chk(res_data == 16'hFFFD, "R3 2-5", res_data, 16'hFFFD);
        send(1, 3'd0, 16'd300, "R3 m1");
        send(1, 3'd0, 16'd300, "R3 m2");
        send(1, 3'd3, 16'd0, "R3 mul");
        send(1, 3'd4, 16'd0, "R3 end mul");
        chk(res_data == 16'd24464, "R3 mul wrap", res_data, 24464);

        // R5 underflow on empty and on one entry, R7 end on empty
        send(1, 3'd1, 16'd0, "R5 op empty");
        send(1, 3'd4, 16'd0, "R7 end empty");
        send(1, 3'd0, 16'd9, "R5 one");
        send(1, 3'd3, 16'd0, "R5 op one");
        send(1, 3'd4, 16'd0, "R5 value kept");
        chk(res_data == 16'd9, "R5 contents", res_data, 9);

        // R6 fill, overflow, then unwind through the shift chain
        for (int i = 1; i <= DP; i++) send(1, 3'd0, 16'(i * 10), "R6 fill");
        send(1, 3'd0, 16'd999, "R6 overflow");
        for (int i = 0; i < DP - 1; i++) send(1, 3'd2, 16'd0, "R6 unwind");
        send(1, 3'd4, 16'd0, "R6 chain end");

        // R8 idle and unused codes
        send(1, 3'd0, 16'd77, "R8 setup");
        send(0, 3'd1, 16'd0, "R8 invalid");
        send(1, 3'd5, 16'd0, "R8 code5");
        send(1, 3'd7, 16'd0, "R8 code7");
        send(1, 3'd4, 16'd0, "R8 end");
        chk(res_data == 16'd77, "R8 untouched", res_data, 77);

        // R9 random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [2:0] op;
            r = int'($urandom_range(0, 99));
            if (r < 45)      op = 3'd0;
            else if (r < 75) op = 3'(1 + $urandom_range(0, 2));
            else if (r < 85) op = 3'd4;
            else             op = 3'(5 + $urandom_range(0, 2));
            send(r < 95, op, 16'($urandom), "R9 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule